// File: doc/BRIEF.md
# Piezo Drive Configuration I2C Target

This block is a write-only I2C target that holds the settings of a piezoelectric actuator pulse driver. It watches SCL and SDA, which have been brought into the system clock domain. Both lines pass through a synchroniser and a short glitch filter. The block then finds START and STOP conditions and checks the first byte against its fixed target address. It then takes a register pointer and one or more data bytes. It acknowledges each accepted byte by pulling SDA low through an open-drain enable.

The register set holds the following settings:
- the drive direction and an outstanding pulse budget;
- a control byte with the init-skip flag, the swing-back code, the clock divider select and the gate mode;
- five 8-bit waveform and step settings;
- a 4-bit initialisation move code.

Pulse counts written to register 0 add to the budget rather than replace it. The budget saturates, and it restarts when the direction flips. Every data byte accepted for register 0 produces a one-cycle strobe for the downstream sequencer. A test input, held high during reset, loads fixed presets, and while it stays high all bus writes are dropped.

Top module: `piezo_cfg_i2c`

## Requirements
- R1: The block acknowledges a first byte only when it equals 0xE4 (target address 1110010 followed by a 0 write bit). Any other first byte, including 0xE5, gets no ACK, and the rest of that transfer changes no register.
- R2: For each accepted byte, `sda_pull_low` rises while SCL is low after the eighth clock and falls again on the falling edge of the ninth clock. At all other times it stays low (released).
- R3: A register-0 write takes bit 7 as the direction (0 = infinity, 1 = macro) and bits 6:0 as a pulse count. When bit 7 equals the current direction, the count is added to `pulse_budget`, which saturates at 512.
- R4: A register-0 write whose bit 7 differs from the current direction stores the new direction and sets `pulse_budget` to that byte's count alone. A count of 0 therefore leaves the budget at 0, which stops motion.
- R5: Register 1 maps D0 to `init_skip`, D2:D1 to `swing_code`, D4:D3 to `clk_div_sel` and D7 to `gate_mode`. D6:D5 are discarded.
- R6: Registers 2 to 6 are 8-bit: 2 = `period_cnt`, 3 = `gate_a_end`, 4 = `gate_b_start`, 5 = `gate_b_end`, 6 = `step_cnt`. Register 7 keeps its low nibble in `init_move_code`.
- R7: Each further data byte in one transfer goes to the next register address. Register addresses of 8 and above write nothing.
- R8: `pulse_cmd` is high for exactly one cycle after the ACK of each data byte written to register 0.
- R9: A reset with `test_mode` low clears every register output and the budget to 0, and releases SDA.
- R10: A reset with `test_mode` high loads period 115, gate A end 21, gate B start 24, gate B end 54, step 139 and init move code 10; all other fields are 0. While `test_mode` stays high, data bytes are ignored and `pulse_cmd` stays low.
- R11: A repeated START in the middle of a transfer restarts address matching. Register bytes from the abandoned transfer that were not yet acknowledged are not written.
- R12: A pulse on SCL shorter than three system-clock samples is not taken as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Loads presets on reset and blocks bus writes |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| dir_macro | output | 1 | Drive direction, 1 = macro |
| pulse_budget | output | 10 | Outstanding drive pulses, 0 to 512 |
| pulse_cmd | output | 1 | One-cycle strobe on a register-0 write |
| init_skip | output | 1 | 1 skips the start-up initialisation |
| swing_code | output | 2 | Swing-back count code |
| clk_div_sel | output | 2 | Drive clock divider select |
| gate_mode | output | 1 | Gate output mode |
| period_cnt | output | 8 | Clocks per period minus one |
| gate_a_end | output | 8 | Gate A end count |
| gate_b_start | output | 8 | Gate B start count |
| gate_b_end | output | 8 | Gate B end count |
| step_cnt | output | 8 | Periods per step minus one |
| init_move_code | output | 4 | Initialisation move count code |

## Verification
The bench pushes the pulse budget across its 512 ceiling and flips the direction with both non-zero and zero counts. A design that wraps the sum, or that keeps adding after a direction change, would show a wrong budget. It sends foreign and read addresses, and a register pointer past the top register. A design that acknowledged those or decoded the pointer modulo eight would answer or write where it must stay silent. It also fires a repeated START in mid-transfer, inserts a two-sample SCL glitch inside a byte, and writes under test mode. A design without a real filter would misalign bits, and one that honoured test-mode writes would lose the presets.

// File: rtl/piezo_cfg_pkg.sv
package piezo_cfg_pkg;

    localparam logic [6:0] TGT_ADDR   = 7'b1110010;
    localparam int         BUDGET_MAX = 512;
    localparam int         BUDGET_W   = $clog2(BUDGET_MAX + 1);
    localparam logic [BUDGET_W:0] BUDGET_CAP = (BUDGET_W + 1)'(BUDGET_MAX);

    localparam logic [7:0] PRE_PERIOD  = 8'd115;
    localparam logic [7:0] PRE_GATE_AE = 8'd21;
    localparam logic [7:0] PRE_GATE_BS = 8'd24;
    localparam logic [7:0] PRE_GATE_BE = 8'd54;
    localparam logic [7:0] PRE_STEP    = 8'd139;
    localparam logic [3:0] PRE_INITMOV = 4'd10;

    typedef enum logic [1:0] {PH_IDLE, PH_BITS, PH_ACK, PH_SKIP} phase_e;
    typedef enum logic [1:0] {BK_ADDR, BK_REG, BK_DATA} byte_kind_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    typedef struct packed {
        logic       gate_mode;
        logic [1:0] clk_div_sel;
        logic [1:0] swing_code;
        logic       init_skip;
    } ctrl_t;

    typedef struct packed {
        logic                dir_macro;
        logic [BUDGET_W-1:0] budget;
        ctrl_t               ctrl;
        logic [7:0]          period;
        logic [7:0]          gate_a_end;
        logic [7:0]          gate_b_start;
        logic [7:0]          gate_b_end;
        logic [7:0]          step;
        logic [3:0]          initmov;
    } cfg_t;

    function automatic logic [BUDGET_W-1:0] budget_add(
        input logic [BUDGET_W-1:0] cur,
        input logic [6:0]          inc
    );
        logic [BUDGET_W:0] sum;
        sum = {1'b0, cur} + {{(BUDGET_W - 6){1'b0}}, inc};
        return (sum > BUDGET_CAP) ? BUDGET_CAP[BUDGET_W-1:0] : sum[BUDGET_W-1:0];
    endfunction

endpackage

// File: rtl/pcfg_line_filter.sv
module pcfg_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end

    AST_FILT_AGREE: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> ($past(hist_q) == '0 || $past(hist_q) == '1)); // R12

endmodule

// File: rtl/pcfg_bus_engine.sv
module pcfg_bus_engine
    import piezo_cfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output logic    sda_low,
    output wr_req_t wr
);
    logic       scl_q, sda_q;
    logic [7:0] shreg;
    logic [3:0] bitcnt;
    logic [7:0] ptr;
    phase_e     phase;
    byte_kind_e kind;

    wire scl_rise = scl & ~scl_q;
    wire scl_fall = ~scl & scl_q;
    wire start_c  = scl & scl_q & sda_q & ~sda;
    wire stop_c   = scl & scl_q & ~sda_q & sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            shreg   <= '0;
            bitcnt  <= '0;
            ptr     <= '0;
            phase   <= PH_IDLE;
            kind    <= BK_ADDR;
            sda_low <= 1'b0;
            wr      <= '0;
        end else begin
            scl_q    <= scl;
            sda_q    <= sda;
            wr.valid <= 1'b0;
            if (start_c) begin
                phase   <= PH_BITS;
                kind    <= BK_ADDR;
                bitcnt  <= '0;
                sda_low <= 1'b0;
            end else if (stop_c) begin
                phase   <= PH_IDLE;
                sda_low <= 1'b0;
            end else begin
                case (phase)
                    PH_BITS: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (kind == BK_ADDR && shreg != {TGT_ADDR, 1'b0}) begin
                                phase <= PH_SKIP;
                            end else begin
                                sda_low <= 1'b1;
                                phase   <= PH_ACK;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            sda_low <= 1'b0;
                            phase   <= PH_BITS;
                            bitcnt  <= '0;
                            case (kind)
                                BK_ADDR: kind <= BK_REG;
                                BK_REG: begin
                                    ptr  <= shreg;
                                    kind <= BK_DATA;
                                end
                                default: begin
                                    wr.valid <= 1'b1;
                                    wr.addr  <= ptr;
                                    wr.data  <= shreg;
                                    ptr      <= ptr + 8'd1;
                                end
                            endcase
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low) |-> !scl); // R2
    AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_low) && kind == BK_ADDR) |-> shreg == {TGT_ADDR, 1'b0}); // R1

endmodule

// File: rtl/pcfg_regs.sv
module pcfg_regs
    import piezo_cfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    test_mode,
    input  wr_req_t wr,
    output cfg_t    cfg,
    output logic    pulse_cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            pulse_cmd <= 1'b0;
            if (test_mode) begin
                cfg.period       <= PRE_PERIOD;
                cfg.gate_a_end   <= PRE_GATE_AE;
                cfg.gate_b_start <= PRE_GATE_BS;
                cfg.gate_b_end   <= PRE_GATE_BE;
                cfg.step         <= PRE_STEP;
                cfg.initmov      <= PRE_INITMOV;
            end
        end else begin
            pulse_cmd <= 1'b0;
            if (wr.valid && !test_mode) begin
                case (wr.addr)
                    8'd0: begin
                        pulse_cmd <= 1'b1;
                        if (wr.data[7] != cfg.dir_macro) begin
                            cfg.dir_macro <= wr.data[7];
                            cfg.budget    <= {{(BUDGET_W - 7){1'b0}}, wr.data[6:0]};
                        end else begin
                            cfg.budget <= budget_add(cfg.budget, wr.data[6:0]);
                        end
                    end
                    8'd1: begin
                        cfg.ctrl.gate_mode   <= wr.data[7];
                        cfg.ctrl.clk_div_sel <= wr.data[4:3];
                        cfg.ctrl.swing_code  <= wr.data[2:1];
                        cfg.ctrl.init_skip   <= wr.data[0];
                    end
                    8'd2: cfg.period       <= wr.data;
                    8'd3: cfg.gate_a_end   <= wr.data;
                    8'd4: cfg.gate_b_start <= wr.data;
                    8'd5: cfg.gate_b_end   <= wr.data;
                    8'd6: cfg.step         <= wr.data;
                    8'd7: cfg.initmov      <= wr.data[3:0];
                    default: ;
                endcase
            end
        end
    end

    AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (rst)
        cfg.budget <= BUDGET_CAP[BUDGET_W-1:0]); // R3
    AST_BUDGET_GROWS: assert property (@(posedge clk) disable iff (rst)
        $stable(cfg.dir_macro) |-> cfg.budget >= $past(cfg.budget)); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_cmd |=> !pulse_cmd); // R8
    AST_TEST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        test_mode |=> ($stable(cfg) && !pulse_cmd)); // R10

endmodule

// File: rtl/piezo_cfg_i2c.sv
module piezo_cfg_i2c
    import piezo_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                test_mode,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_pull_low,
    output logic                dir_macro,
    output logic [BUDGET_W-1:0] pulse_budget,
    output logic                pulse_cmd,
    output logic                init_skip,
    output logic [1:0]          swing_code,
    output logic [1:0]          clk_div_sel,
    output logic                gate_mode,
    output logic [7:0]          period_cnt,
    output logic [7:0]          gate_a_end,
    output logic [7:0]          gate_b_start,
    output logic [7:0]          gate_b_end,
    output logic [7:0]          step_cnt,
    output logic [3:0]          init_move_code
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean_lines;
    wr_req_t              wr;
    cfg_t                 cfg;

    assign raw_lines = {scl_in, sda_in};

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        pcfg_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) i_filter (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[gi]),
            .dout (clean_lines[gi])
        );
    end

    pcfg_bus_engine i_engine (
        .clk     (clk),
        .rst     (rst),
        .scl     (clean_lines[1]),
        .sda     (clean_lines[0]),
        .sda_low (sda_pull_low),
        .wr      (wr)
    );

    pcfg_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .test_mode (test_mode),
        .wr        (wr),
        .cfg       (cfg),
        .pulse_cmd (pulse_cmd)
    );

    assign dir_macro      = cfg.dir_macro;
    assign pulse_budget   = cfg.budget;
    assign init_skip      = cfg.ctrl.init_skip;
    assign swing_code     = cfg.ctrl.swing_code;
    assign clk_div_sel    = cfg.ctrl.clk_div_sel;
    assign gate_mode      = cfg.ctrl.gate_mode;
    assign period_cnt     = cfg.period;
    assign gate_a_end     = cfg.gate_a_end;
    assign gate_b_start   = cfg.gate_b_start;
    assign gate_b_end     = cfg.gate_b_end;
    assign step_cnt       = cfg.step;
    assign init_move_code = cfg.initmov;

endmodule

// File: tb/test_piezo_cfg_i2c.sv
`timescale 1ns/1ps
module test_piezo_cfg_i2c;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, test_mode = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull_low, dir_macro, pulse_cmd, init_skip, gate_mode;
    logic [9:0] pulse_budget;
    logic [1:0] swing_code, clk_div_sel;
    logic [7:0] period_cnt, gate_a_end, gate_b_start, gate_b_end, step_cnt;
    logic [3:0] init_move_code;
    wire sda_bus = sda_m & ~sda_pull_low;

    piezo_cfg_i2c i_piezo_cfg_i2c (
        .clk(clk), .rst(rst), .test_mode(test_mode), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_pull_low(sda_pull_low), .dir_macro(dir_macro), .pulse_budget(pulse_budget),
        .pulse_cmd(pulse_cmd), .init_skip(init_skip), .swing_code(swing_code),
        .clk_div_sel(clk_div_sel), .gate_mode(gate_mode), .period_cnt(period_cnt),
        .gate_a_end(gate_a_end), .gate_b_start(gate_b_start), .gate_b_end(gate_b_end),
        .step_cnt(step_cnt), .init_move_code(init_move_code)
    );

    localparam int T = 12;
    int  n_chk = 0, n_bad = 0, pulses = 0, wide = 0;
    logic pulse_prev = 1'b0;
    bit  done = 1'b0;

    // {reg address, data byte, expected observed value}
    localparam logic [25:0] VEC [16] = '{
        {8'd2, 8'd129, 10'd129}, {8'd3, 8'd21,  10'd21},  {8'd4, 8'd24,  10'd24},
        {8'd5, 8'd54,  10'd54},  {8'd6, 8'd200, 10'd200}, {8'd7, 8'hFA,  10'd10},
        {8'd1, 8'hFF,  10'h09F}, {8'd0, 8'h05,  10'd5},   {8'd0, 8'h7F,  10'd132},
        {8'd0, 8'h7F,  10'd259}, {8'd0, 8'h7F,  10'd386}, {8'd0, 8'h7F,  10'd512},
        {8'd0, 8'h10,  10'd512}, {8'd0, 8'h83,  10'd3},   {8'd0, 8'h80,  10'd3},
        {8'd0, 8'h00,  10'd0}
    };

    always @(negedge clk) begin
        if (!rst) begin
            if (pulse_cmd) pulses++;
            if (pulse_cmd && pulse_prev) wide++;
        end
        pulse_prev = pulse_cmd;
    end

    function automatic logic [9:0] observe(input logic [7:0] a);
        case (a)
            8'd0: return pulse_budget;
            8'd1: return {2'b00, gate_mode, 2'b00, clk_div_sel, swing_code, init_skip};
            8'd2: return {2'b00, period_cnt};
            8'd3: return {2'b00, gate_a_end};
            8'd4: return {2'b00, gate_b_start};
            8'd5: return {2'b00, gate_b_end};
            8'd6: return {2'b00, step_cnt};
            default: return {6'd0, init_move_code};
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hold(T); scl_m = 1'b1; hold(T);
        sda_m = 1'b0; hold(T); scl_m = 1'b0; hold(T);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hold(T); scl_m = 1'b1; hold(T); sda_m = 1'b1; hold(2 * T);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit ack;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(T); scl_m = 1'b1; hold(2 * T); scl_m = 1'b0; hold(T);
        end
        sda_m = 1'b1; hold(T); scl_m = 1'b1; hold(T);
        ack = !sda_bus;
        hold(T); scl_m = 1'b0; hold(T);
        chk(req, int'(ack), int'(exp_ack));
        hold(T);
        chk("R2 SDA released after ACK", int'(sda_pull_low), 0);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        i2c_start();
        send_byte(8'hE4, 1'b1, "R1 address ACK");
        send_byte(a, 1'b1, "R2 pointer ACK");
        send_byte(d, 1'b1, "R2 data ACK");
        i2c_stop();
        hold(4 * T);
    endtask

    task automatic do_reset(input logic tm);
        test_mode = tm; rst = 1'b1; hold(4); rst = 1'b0; hold(4);
    endtask

    initial begin
        do_reset(1'b0);
        // R9: reset state
        for (int a = 0; a < 8; a++) chk("R9 reset value", int'(observe(8'(a))), 0);
        chk("R9 dir after reset", int'(dir_macro), 0);
        chk("R9 SDA released", int'(sda_pull_low), 0);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < 16; i++) begin
            wr_reg(VEC[i][25:18], VEC[i][17:10]);
            chk($sformatf("R3/R4/R5/R6 vector %0d", i),
                int'(observe(VEC[i][25:18])), int'(VEC[i][9:0]));
        end
        chk("R4 dir back to infinity", int'(dir_macro), 0);

        // R4 direction flip with count
        wr_reg(8'd0, 8'h85);
        chk("R4 dir macro", int'(dir_macro), 1);
        chk("R4 budget reloaded", int'(pulse_budget), 5);
        wr_reg(8'd0, 8'h00);
        chk("R4 stop budget", int'(pulse_budget), 0);

        // R7 multi-byte starting at reg0
        i2c_start();
        send_byte(8'hE4, 1'b1, "R1 address ACK");
        send_byte(8'd0, 1'b1, "R2 pointer ACK");
        send_byte(8'h02, 1'b1, "R7 data0 ACK");
        send_byte(8'hFF, 1'b1, "R7 data1 ACK");
        i2c_stop(); hold(4 * T);
        chk("R7 reg0 via burst", int'(pulse_budget), 2);
        chk("R7 reg1 via burst", int'(observe(8'd1)), 'h9F);
        chk("R8 pulse count", pulses, 12);
        chk("R8 pulse width", wide, 0);

        // R12 SCL glitch inside transfer
        i2c_start();
        send_byte(8'hE4, 1'b1, "R1 address ACK");
        send_byte(8'd2, 1'b1, "R2 pointer ACK");
        scl_m = 1'b1; hold(2); scl_m = 1'b0; hold(T);
        send_byte(8'h5A, 1'b1, "R12 data ACK after glitch");
        i2c_stop(); hold(4 * T);
        chk("R12 glitch ignored", int'(period_cnt), 'h5A);

        // R1 foreign and read addresses
        i2c_start();
        send_byte(8'hC4, 1'b0, "R1 foreign address NACK");
        send_byte(8'd2, 1'b0, "R1 skipped pointer");
        send_byte(8'h11, 1'b0, "R1 skipped data");
        i2c_stop(); hold(4 * T);
        chk("R1 foreign write ignored", int'(period_cnt), 'h5A);
        i2c_start();
        send_byte(8'hE5, 1'b0, "R1 read bit NACK");
        i2c_stop(); hold(4 * T);

        // R7 burst across top register
        i2c_start();
        send_byte(8'hE4, 1'b1, "R1 address ACK");
        send_byte(8'd5, 1'b1, "R2 pointer ACK");
        send_byte(8'h40, 1'b1, "R7 burst ACK");
        send_byte(8'h41, 1'b1, "R7 burst ACK");
        send_byte(8'h0C, 1'b1, "R7 burst ACK");
        send_byte(8'hEE, 1'b1, "R7 burst ACK");
        i2c_stop(); hold(4 * T);
        chk("R7 reg5", int'(gate_b_end), 'h40);
        chk("R7 reg6", int'(step_cnt), 'h41);
        chk("R7 reg7", int'(init_move_code), 12);
        chk("R7 reg8 no wrap to reg0", int'(pulse_budget), 2);
        wr_reg(8'd9, 8'hFF);
        chk("R7 reg9 no wrap to reg1", int'(observe(8'd1)), 'h9F);
        chk("R7 reg9 no effect", int'(period_cnt), 'h5A);

        // R11 repeated start
        i2c_start();
        send_byte(8'hE4, 1'b1, "R1 address ACK");
        send_byte(8'd3, 1'b1, "R2 pointer ACK");
        i2c_start();
        send_byte(8'hE4, 1'b1, "R11 address ACK after restart");
        send_byte(8'd4, 1'b1, "R2 pointer ACK");
        send_byte(8'h33, 1'b1, "R2 data ACK");
        i2c_stop(); hold(4 * T);
        chk("R11 new target written", int'(gate_b_start), 'h33);
        chk("R11 abandoned target kept", int'(gate_a_end), 21);

        // R10 test-mode presets
        do_reset(1'b1);
        chk("R10 preset period", int'(period_cnt), 115);
        chk("R10 preset gate A end", int'(gate_a_end), 21);
        chk("R10 preset gate B start", int'(gate_b_start), 24);
        chk("R10 preset gate B end", int'(gate_b_end), 54);
        chk("R10 preset step", int'(step_cnt), 139);
        chk("R10 preset init move", int'(init_move_code), 10);
        chk("R10 budget zero", int'(pulse_budget), 0);
        wr_reg(8'd2, 8'd5);
        wr_reg(8'd0, 8'h05);
        chk("R10 write ignored", int'(period_cnt), 115);
        chk("R10 budget unchanged", int'(pulse_budget), 0);
        chk("R10 no strobe", pulses, 12);
        do_reset(1'b0);
        chk("R9 clears presets", int'(period_cnt), 0);
        chk("R9 clears init move", int'(init_move_code), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule